// File: doc/BRIEF.md
# Bus Arbitration and Target Selection Sequencer

This block is the initiator-side engine that claims a parallel SCSI bus and selects one target. After a start pulse it waits for the bus to be idle, arbitrates by placing its own one-hot ID bit on the data lines, and checks for higher-priority contenders. If it wins, it runs the timed selection handshake. In that handshake it raises ATN while SEL is still held and before BSY is released, so the target is obliged to enter a message-out phase straight after selection.

Every bus signal is treated as open-collector. The block only reports the lines it wants to pull low through its `drv_*` outputs. It samples the wired bus state on its `bus_*` inputs, and that state includes its own drive. Each attempt ends with a one-cycle completion pulse and one of six outcome codes. On a win the block also presents an IDENTIFY byte that carries the LUN, for a separate transfer engine to send. It keeps ATN asserted until the next start so that the hand-off has no gap. All delays and timeouts are clock-cycle counts set by parameters.

Top module: `scsi_sel_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `ident_valid` and every `drv_*` output are 0.
- R2: Arbitration begins only after BSY and SEL have both been seen deasserted for `BUS_FREE_CYC` consecutive cycles. Any assertion of either line restarts that count.
- R3: If the bus is not found free within `ARB_TMO_CYC` cycles of the start, the block ends with result code 3 and releases all lines.
- R4: Arbitration drives BSY and the one-hot pattern `1 << init_id` on the data lines for `ARB_DLY_CYC` cycles. If a data bit above `init_id` is set at the end of that window, the block ends with result code 2 and releases the bus. Bits below `init_id` have no effect.
- R5: After winning, the block drives SEL together with BSY for `SETTLE_CYC` cycles and then checks the higher bits again. A contender seen at that point also gives result code 2.
- R6: Selection drives BSY, SEL and ATN with the data pattern `(1 << init_id) | (1 << targ_id)` for `2*DESKEW_CYC` cycles. It then releases BSY while keeping SEL, ATN and the data, for `DESKEW_CYC` cycles.
- R7: The block then waits up to `SEL_TMO_CYC` cycles for BSY from the target. On expiry it ends with result code 4 and releases all lines.
- R8: While waiting for the target's BSY, SEL and I/O seen together end the attempt with result code 5 and release all lines. This check has priority over BSY seen in the same cycle.
- R9: Once BSY is seen, the block holds SEL, ATN and the data for `2*DESKEW_CYC` cycles. It then releases SEL and the data while keeping ATN, and waits up to `SEL_TMO_CYC`'s sibling `REQ_TMO_CYC` cycles for REQ. On expiry it ends with result code 6.
- R10: On REQ the block ends with result code 1 and pulses `ident_valid` together with `done`. `ident_byte` is then 0x80 with the LUN in bits 2:0. ATN stays asserted until the next accepted start.
- R11: `done` is a single-cycle pulse and `result` is valid with it. A start seen while `busy` is 1 is ignored and the IDs latched at the accepted start are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an attempt (accepted only when idle) |
| init_id | input | 3 | Own bus ID |
| targ_id | input | 3 | Target bus ID |
| lun | input | 3 | Logical unit for the IDENTIFY byte |
| bus_bsy_in | input | 1 | Wired BSY state, 1 = asserted |
| bus_sel_in | input | 1 | Wired SEL state |
| bus_io_in | input | 1 | Wired I/O state |
| bus_req_in | input | 1 | Wired REQ state |
| bus_data_in | input | 8 | Wired data line state |
| drv_bsy | output | 1 | Pull BSY |
| drv_sel | output | 1 | Pull SEL |
| drv_atn | output | 1 | Pull ATN |
| drv_data_en | output | 1 | Data drive active |
| drv_data | output | 8 | Data bits to pull |
| busy | output | 1 | Attempt in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | 1 won, 2 lost, 3 bus-free timeout, 4 selection timeout, 5 reselection, 6 REQ timeout |
| ident_valid | output | 1 | IDENTIFY byte valid (with a win) |
| ident_byte | output | 8 | IDENTIFY message byte |

## Verification
The sequence is run against a quiet bus, against a bus that is busy at the start and then glitches SEL partway through the idle count, and against a bus that never goes idle. These cases separate a correct restart of the idle count from the outer timeout. Contenders are placed below the own ID, above it during arbitration, and above it only during the settle window. This shows that the priority mask is one-sided and that the second check really samples. Four target behaviours are used: full response, silence, BSY without REQ, and SEL with I/O. Each ends in a different outcome, and a start pulse issued mid-attempt with other IDs shows that the latched IDs hold.

// File: rtl/scsi_sel_pkg.sv
// Shared types for the arbitration and selection sequencer.
package scsi_sel_pkg;

    // Completion codes reported on the result port.
    typedef enum logic [2:0] {
        RES_NONE    = 3'd0,
        RES_WON     = 3'd1,
        RES_LOST    = 3'd2,
        RES_ARB_TMO = 3'd3,
        RES_SEL_TMO = 3'd4,
        RES_RESEL   = 3'd5,
        RES_REQ_TMO = 3'd6
    } sel_result_e;

    // Sequencer phases, in the order they are walked.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FREE,
        ST_ARB,
        ST_SETTLE,
        ST_SEL_A,
        ST_SEL_B,
        ST_WAIT_BSY,
        ST_HOLD,
        ST_WAIT_REQ
    } seq_state_e;

endpackage

// File: rtl/sel_phase_timer.sv
// Cycle counter for one sequencer phase.
// Counts from zero after each clear; `last` is high in the cycle where the
// count equals limit-1. Assumes limit >= 1 and that the owner clears it
// before it could wrap.
module sel_phase_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    // Count up, restarting on clear or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt_q <= '0;
        else               cnt_q <= cnt_q + CNT_W'(1);
    end

    assign last = (cnt_q == limit - CNT_W'(1));
endmodule

// File: rtl/sel_bus_free.sv
// Bus-idle qualifier.
// While enabled, counts consecutive cycles with BSY and SEL both released.
// `free_ok` is high in the cycle that completes `limit` such cycles. Any
// activity, or a drop of enable, restarts the count.
module sel_bus_free #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             bus_bsy,
    input  logic             bus_sel,
    input  logic [CNT_W-1:0] limit,
    output logic             free_ok
);
    logic [CNT_W-1:0] cnt_q;
    logic             active;

    assign active = bus_bsy || bus_sel;

    // Track the length of the current idle stretch.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || active) cnt_q <= '0;
        else                             cnt_q <= cnt_q + CNT_W'(1);
    end

    assign free_ok = enable && !active && (cnt_q == limit - CNT_W'(1));
endmodule

// File: rtl/sel_id_logic.sv
// ID decoding for arbitration and selection.
// Builds the one-hot own bit, the own|target selection pattern, and flags
// any data bit of higher priority (higher index) than the own ID.
// Assumes DATA_W is a power of two.
module sel_id_logic #(
    parameter int DATA_W = 8,
    localparam int ID_W  = $clog2(DATA_W)
) (
    input  logic [ID_W-1:0]   own_id,
    input  logic [ID_W-1:0]   targ_id,
    input  logic [DATA_W-1:0] bus_data,
    output logic [DATA_W-1:0] own_bit,
    output logic [DATA_W-1:0] sel_pattern,
    output logic              higher_seen
);
    logic [DATA_W-1:0] targ_bit;
    logic [DATA_W-1:0] above_mask;

    // One decoder slice per data line.
    for (genvar i = 0; i < DATA_W; i++) begin : g_line
        assign own_bit[i]    = (own_id  == ID_W'(i));
        assign targ_bit[i]   = (targ_id == ID_W'(i));
        assign above_mask[i] = (ID_W'(i) > own_id);
    end

    assign sel_pattern = own_bit | targ_bit;
    assign higher_seen = |(bus_data & above_mask);
endmodule

// File: rtl/scsi_sel_seq.sv
// Initiator arbitration and selection sequencer (top).
// Waits for an idle bus, arbitrates with its own ID, selects the target with
// ATN raised before BSY is released, and reports one outcome per start.
// All bus outputs are pull requests for open-collector lines; bus inputs are
// the wired state including this block's own drive. Timing is in cycles.
module scsi_sel_seq
    import scsi_sel_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int BUS_FREE_CYC = 8,
    parameter int ARB_DLY_CYC  = 24,
    parameter int SETTLE_CYC   = 12,
    parameter int DESKEW_CYC   = 4,
    parameter int SEL_TMO_CYC  = 2500,
    parameter int REQ_TMO_CYC  = 10000,
    parameter int ARB_TMO_CYC  = 10000,
    localparam int ID_W        = $clog2(DATA_W),
    localparam int LUN_W       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ID_W-1:0]   init_id,
    input  logic [ID_W-1:0]   targ_id,
    input  logic [LUN_W-1:0]  lun,
    input  logic              bus_bsy_in,
    input  logic              bus_sel_in,
    input  logic              bus_io_in,
    input  logic              bus_req_in,
    input  logic [DATA_W-1:0] bus_data_in,
    output logic              drv_bsy,
    output logic              drv_sel,
    output logic              drv_atn,
    output logic              drv_data_en,
    output logic [DATA_W-1:0] drv_data,
    output logic              busy,
    output logic              done,
    output logic [2:0]        result,
    output logic              ident_valid,
    output logic [7:0]        ident_byte
);
    localparam int T_WAIT = (SEL_TMO_CYC > REQ_TMO_CYC) ? SEL_TMO_CYC : REQ_TMO_CYC;
    localparam int T_ARB  = (ARB_DLY_CYC > SETTLE_CYC) ? ARB_DLY_CYC : SETTLE_CYC;
    localparam int T_SHRT = (2 * DESKEW_CYC > T_ARB) ? 2 * DESKEW_CYC : T_ARB;
    localparam int PH_MAX = (T_WAIT > T_SHRT) ? T_WAIT : T_SHRT;
    localparam int PH_W   = $clog2(PH_MAX + 1);
    localparam int WD_W   = $clog2(ARB_TMO_CYC + 1);
    localparam int BF_W   = $clog2(BUS_FREE_CYC + 1);

    seq_state_e        state_q, state_d;
    sel_result_e       result_q, result_d;
    logic              finish;
    logic [ID_W-1:0]   iid_q, tid_q;
    logic [LUN_W-1:0]  lun_q;
    logic              done_q, ident_q, atn_keep_q;
    logic [PH_W-1:0]   ph_limit;
    logic              ph_clr, ph_last, wd_last, free_ok, higher_seen;
    logic [DATA_W-1:0] own_bit, sel_pattern;

    sel_id_logic #(.DATA_W(DATA_W)) u_ids (
        .own_id      (iid_q),
        .targ_id     (tid_q),
        .bus_data    (bus_data_in),
        .own_bit     (own_bit),
        .sel_pattern (sel_pattern),
        .higher_seen (higher_seen)
    );

    sel_bus_free #(.CNT_W(BF_W)) u_free (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (state_q == ST_FREE),
        .bus_bsy (bus_bsy_in),
        .bus_sel (bus_sel_in),
        .limit   (BF_W'(BUS_FREE_CYC)),
        .free_ok (free_ok)
    );

    sel_phase_timer #(.CNT_W(WD_W)) u_watchdog (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != ST_FREE),
        .limit (WD_W'(ARB_TMO_CYC)),
        .last  (wd_last)
    );

    sel_phase_timer #(.CNT_W(PH_W)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ph_clr),
        .limit (ph_limit),
        .last  (ph_last)
    );

    // Pick the length of the current phase.
    always_comb begin
        case (state_q)
            ST_ARB:      ph_limit = PH_W'(ARB_DLY_CYC);
            ST_SETTLE:   ph_limit = PH_W'(SETTLE_CYC);
            ST_SEL_A:    ph_limit = PH_W'(2 * DESKEW_CYC);
            ST_SEL_B:    ph_limit = PH_W'(DESKEW_CYC);
            ST_WAIT_BSY: ph_limit = PH_W'(SEL_TMO_CYC);
            ST_HOLD:     ph_limit = PH_W'(2 * DESKEW_CYC);
            ST_WAIT_REQ: ph_limit = PH_W'(REQ_TMO_CYC);
            default:     ph_limit = PH_W'(1);
        endcase
    end

    // Next phase and the outcome of a finishing attempt.
    always_comb begin
        state_d  = state_q;
        result_d = RES_NONE;
        finish   = 1'b0;
        case (state_q)
            ST_IDLE:     if (start) state_d = ST_FREE;
            ST_FREE: begin
                if (wd_last)      begin finish = 1'b1; result_d = RES_ARB_TMO; end
                else if (free_ok) state_d = ST_ARB;
            end
            ST_ARB: if (ph_last) begin
                if (higher_seen) begin finish = 1'b1; result_d = RES_LOST; end
                else             state_d = ST_SETTLE;
            end
            ST_SETTLE: if (ph_last) begin
                if (higher_seen) begin finish = 1'b1; result_d = RES_LOST; end
                else             state_d = ST_SEL_A;
            end
            ST_SEL_A:    if (ph_last) state_d = ST_SEL_B;
            ST_SEL_B:    if (ph_last) state_d = ST_WAIT_BSY;
            ST_WAIT_BSY: begin
                if (bus_sel_in && bus_io_in) begin finish = 1'b1; result_d = RES_RESEL; end
                else if (bus_bsy_in)         state_d = ST_HOLD;
                else if (ph_last)            begin finish = 1'b1; result_d = RES_SEL_TMO; end
            end
            ST_HOLD:     if (ph_last) state_d = ST_WAIT_REQ;
            ST_WAIT_REQ: begin
                if (bus_req_in)   begin finish = 1'b1; result_d = RES_WON; end
                else if (ph_last) begin finish = 1'b1; result_d = RES_REQ_TMO; end
            end
            default:     state_d = ST_IDLE;
        endcase
        if (finish) state_d = ST_IDLE;
    end

    assign ph_clr = (state_d != state_q) || (state_q == ST_IDLE);

    // Phase register, latched IDs, completion flags and ATN hand-off hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            result_q   <= RES_NONE;
            iid_q      <= '0;
            tid_q      <= '0;
            lun_q      <= '0;
            done_q     <= 1'b0;
            ident_q    <= 1'b0;
            atn_keep_q <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= finish;
            ident_q <= finish && (result_d == RES_WON);
            if (finish) result_q <= result_d;
            if (state_q == ST_IDLE && start) begin
                iid_q      <= init_id;
                tid_q      <= targ_id;
                lun_q      <= lun;
                atn_keep_q <= 1'b0;
            end else if (finish && result_d == RES_WON) begin
                atn_keep_q <= 1'b1;
            end
        end
    end

    // Bus pull requests decoded from the current phase.
    always_comb begin
        drv_bsy     = 1'b0;
        drv_sel     = 1'b0;
        drv_atn     = atn_keep_q;
        drv_data_en = 1'b0;
        drv_data    = '0;
        case (state_q)
            ST_ARB:      begin drv_bsy = 1'b1; drv_data_en = 1'b1; drv_data = own_bit; end
            ST_SETTLE:   begin drv_bsy = 1'b1; drv_sel = 1'b1; drv_data_en = 1'b1; drv_data = own_bit; end
            ST_SEL_A:    begin drv_bsy = 1'b1; drv_sel = 1'b1; drv_atn = 1'b1;
                               drv_data_en = 1'b1; drv_data = sel_pattern; end
            ST_SEL_B, ST_WAIT_BSY, ST_HOLD:
                         begin drv_sel = 1'b1; drv_atn = 1'b1;
                               drv_data_en = 1'b1; drv_data = sel_pattern; end
            ST_WAIT_REQ: drv_atn = 1'b1;
            default:     ;
        endcase
    end

    assign busy        = (state_q != ST_IDLE);
    assign done        = done_q;
    assign result      = result_q;
    assign ident_valid = ident_q;
    assign ident_byte  = {1'b1, {(8 - 1 - LUN_W){1'b0}}, lun_q};
endmodule

// File: rtl/scsi_sel_seq_chk.sv
// Protocol checker for the sequencer, attached by bind.
// Watches only the top-level ports; assumes synchronous active-low reset.
module scsi_sel_seq_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_bsy_in,
    input logic              bus_sel_in,
    input logic              drv_bsy,
    input logic              drv_sel,
    input logic              drv_atn,
    input logic              drv_data_en,
    input logic [DATA_W-1:0] drv_data,
    input logic              busy,
    input logic              done,
    input logic [2:0]        result,
    input logic              ident_valid
);
    // BSY is first pulled only after a cycle of idle bus.
    assert_free_before_arb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_bsy) |-> $past(!bus_bsy_in && !bus_sel_in));

    // Arbitration drives exactly one data bit.
    assert_arb_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_bsy && !drv_sel) |-> (drv_data_en && $countones(drv_data) == 1));

    // BSY is released during selection only with ATN already up.
    assert_atn_before_bsy_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(drv_bsy) && drv_sel) |-> drv_atn);

    // SEL is never pulled outside an attempt.
    assert_sel_only_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        drv_sel |-> busy);

    // A reselection outcome leaves every line released.
    assert_resel_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == 3'd5) |-> (!drv_sel && !drv_bsy && !drv_atn && !drv_data_en));

    // The IDENTIFY strobe appears only with a win.
    assert_ident_with_win_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ident_valid |-> (done && result == 3'd1));

    // Completion is a single-cycle pulse.
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind scsi_sel_seq scsi_sel_seq_chk #(.DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_bsy_in  (bus_bsy_in),
    .bus_sel_in  (bus_sel_in),
    .drv_bsy     (drv_bsy),
    .drv_sel     (drv_sel),
    .drv_atn     (drv_atn),
    .drv_data_en (drv_data_en),
    .drv_data    (drv_data),
    .busy        (busy),
    .done        (done),
    .result      (result),
    .ident_valid (ident_valid)
);

// File: tb/scsi_sel_seq_tb_top.sv
// Bench: behavioural timing model compared against the design every cycle,
// plus a target agent and directed scenarios with outcome checks.
module scsi_sel_seq_tb_top;
    localparam int BF = 8, ARBD = 24, SETL = 12, DSK = 4;
    localparam int SELT = 2500, REQT = 10000, ARBT = 10000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] iid = '0, tid = '0, lun = '0;
    logic ag_bsy = 0, ag_sel = 0, ag_io = 0, ag_req = 0;
    logic scen_bsy = 0, scen_sel = 0;
    logic [7:0] scen_data = '0;
    int ag_mode = 0, ag_cnt = 0;
    logic [2:0] ag_tid = '0;

    logic drv_bsy, drv_sel, drv_atn, drv_data_en, busy, done, ident_valid;
    logic [7:0] drv_data, ident_byte;
    logic [2:0] result;

    wire t_bsy = ag_bsy | scen_bsy;
    wire t_sel = ag_sel | scen_sel;
    wire [7:0] bus_data = (drv_data_en ? drv_data : 8'h00) | scen_data;

    always #5 clk = ~clk;

    scsi_sel_seq #(.DATA_W(8), .BUS_FREE_CYC(BF), .ARB_DLY_CYC(ARBD), .SETTLE_CYC(SETL),
        .DESKEW_CYC(DSK), .SEL_TMO_CYC(SELT), .REQ_TMO_CYC(REQT), .ARB_TMO_CYC(ARBT)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .init_id(iid), .targ_id(tid), .lun(lun),
        .bus_bsy_in(drv_bsy | t_bsy), .bus_sel_in(drv_sel | t_sel), .bus_io_in(ag_io),
        .bus_req_in(ag_req), .bus_data_in(bus_data),
        .drv_bsy(drv_bsy), .drv_sel(drv_sel), .drv_atn(drv_atn), .drv_data_en(drv_data_en),
        .drv_data(drv_data), .busy(busy), .done(done), .result(result),
        .ident_valid(ident_valid), .ident_byte(ident_byte));

    int n_chk = 0, n_err = 0, cyc = 0;
    bit cmp_on = 0;

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    // ---------------- behavioural model ----------------
    logic e_bsy = 0, e_sel = 0, e_atn = 0, e_den = 0, e_busy = 0, e_done = 0, e_iv = 0;
    logic [7:0] e_data = '0;
    int e_res = 0;
    int m_iid = 0, m_tid = 0, m_lun = 0;
    string cur_req = "R1";

    task automatic m_release(input int code, input string rq);
        e_bsy = 0; e_sel = 0; e_den = 0; e_data = '0; e_busy = 0;
        e_done = 1; e_res = code; e_iv = (code == 1); e_atn = (code == 1);
        cur_req = rq;
        @(posedge clk);
        e_done = 0; e_iv = 0;
    endtask

    function automatic bit higher_on(input int own);
        bit h = 0;
        for (int b = own + 1; b < 8; b++) if (scen_data[b]) h = 1;
        return h;
    endfunction

    task automatic m_run();
        int wd = 0, fc = 0;
        m_iid = iid; m_tid = tid; m_lun = lun;
        e_busy = 1; e_atn = 0; e_done = 0; cur_req = "R2";
        forever begin                                   // R2 / R3 idle wait
            @(posedge clk);
            if (wd == ARBT - 1) begin m_release(3, "R3"); return; end
            wd++;
            if (t_bsy || t_sel) fc = 0;
            else if (fc == BF - 1) break;
            else fc++;
        end
        e_bsy = 1; e_den = 1; e_data = 8'(1 << m_iid); cur_req = "R4";
        repeat (ARBD) @(posedge clk);
        if (higher_on(m_iid)) begin m_release(2, "R4"); return; end
        e_sel = 1; cur_req = "R5";
        repeat (SETL) @(posedge clk);
        if (higher_on(m_iid)) begin m_release(2, "R5"); return; end
        e_atn = 1; e_data = 8'((1 << m_iid) | (1 << m_tid)); cur_req = "R6";
        repeat (2 * DSK) @(posedge clk);
        e_bsy = 0;
        repeat (DSK) @(posedge clk);
        cur_req = "R7";
        for (int k = 0; ; k++) begin
            @(posedge clk);
            if ((e_sel | t_sel) && ag_io) begin m_release(5, "R8"); return; end
            if (t_bsy) break;
            if (k == SELT - 1) begin m_release(4, "R7"); return; end
        end
        cur_req = "R9";
        repeat (2 * DSK) @(posedge clk);
        e_sel = 0; e_den = 0; e_data = '0;
        for (int k = 0; ; k++) begin
            @(posedge clk);
            if (ag_req) begin m_release(1, "R10"); return; end
            if (k == REQT - 1) begin m_release(6, "R9"); return; end
        end
    endtask

    always begin
        @(posedge clk);
        if (!rst_n) begin
            e_bsy = 0; e_sel = 0; e_atn = 0; e_den = 0; e_data = '0;
            e_busy = 0; e_done = 0; e_iv = 0;
        end else if (start) begin
            m_run();
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(drv_bsy == e_bsy, cur_req, "drv_bsy", drv_bsy, e_bsy);
            chk(drv_sel == e_sel, cur_req, "drv_sel", drv_sel, e_sel);
            chk(drv_atn == e_atn, cur_req, "drv_atn", drv_atn, e_atn);
            chk(drv_data_en == e_den, cur_req, "drv_data_en", drv_data_en, e_den);
            chk(drv_data == e_data, cur_req, "drv_data", drv_data, e_data);
            chk(busy == e_busy, cur_req, "busy", busy, e_busy);
            chk(done == e_done, "R11", "done", done, e_done);
            chk(ident_valid == e_iv, "R10", "ident_valid", ident_valid, e_iv);
            if (e_done) chk(result == 3'(e_res), "R11", "result", result, e_res);
            if (e_iv) chk(ident_byte == 8'(8'h80 | m_lun), "R10", "ident_byte", ident_byte, 8'h80 | m_lun);
        end
    end

    // ---------------- target agent ----------------
    always @(negedge clk) begin
        if (!rst_n || done) begin
            ag_bsy <= 0; ag_sel <= 0; ag_io <= 0; ag_req <= 0; ag_cnt <= 0;
        end else if (ag_mode != 0 && drv_sel && !drv_bsy && drv_data_en && drv_data[ag_tid]
                     && !ag_bsy && !ag_io) begin
            if (ag_cnt == 3) begin
                if (ag_mode == 3) begin ag_sel <= 1; ag_io <= 1; end
                else ag_bsy <= 1;
                ag_cnt <= 0;
            end else ag_cnt <= ag_cnt + 1;
        end else if (ag_mode == 1 && ag_bsy && !drv_sel && !ag_req) begin
            if (ag_cnt == 5) begin ag_req <= 1; ag_cnt <= 0; end
            else ag_cnt <= ag_cnt + 1;
        end
    end

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 180000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    task automatic launch(input int ii, input int ti, input int lu, input int mode);
        @(negedge clk);
        iid = 3'(ii); tid = 3'(ti); lun = 3'(lu); ag_tid = 3'(ti); ag_mode = mode;
        start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic finish_wait(output int code, output int ident);
        while (!done) @(negedge clk);
        code = result; ident = ident_byte;
        repeat (3) @(negedge clk);
    endtask

    int code, ident;

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1: idle after reset
        chk(!busy && !done && !ident_valid, "R1", "status", {busy, done, ident_valid}, 0);
        chk(!drv_bsy && !drv_sel && !drv_atn && !drv_data_en, "R1", "drives",
            {drv_bsy, drv_sel, drv_atn, drv_data_en}, 0);
        cmp_on = 1;

        // R10: clean win on quiet bus
        launch(6, 1, 5, 1);
        finish_wait(code, ident);
        chk(code == 1, "R10", "win code", code, 1);
        chk(ident == 8'h85, "R10", "identify", ident, 8'h85);
        chk(drv_atn == 1, "R10", "atn held after win", drv_atn, 1);

        // R2: busy bus at start, then a SEL glitch mid-count
        scen_bsy = 1;
        launch(5, 2, 1, 1);
        repeat (30) @(negedge clk);
        scen_bsy = 0;
        repeat (4) @(negedge clk);
        scen_sel = 1;
        @(negedge clk);
        scen_sel = 0;
        finish_wait(code, ident);
        chk(code == 1, "R2", "win after idle", code, 1);

        // R4: contender below own ID is ignored
        scen_data = 8'h04;
        launch(3, 6, 0, 1);
        finish_wait(code, ident);
        scen_data = 8'h00;
        chk(code == 1, "R4", "lower contender", code, 1);

        // R4: contender above own ID wins
        scen_data = 8'h10;
        launch(3, 6, 0, 1);
        finish_wait(code, ident);
        scen_data = 8'h00;
        chk(code == 2, "R4", "higher contender", code, 2);
        chk(!drv_bsy && !drv_data_en, "R4", "released after loss", {drv_bsy, drv_data_en}, 0);

        // R5: contender appears during settle
        launch(2, 0, 1, 1);
        while (!drv_sel) @(negedge clk);
        scen_data = 8'h80;
        finish_wait(code, ident);
        scen_data = 8'h00;
        chk(code == 2, "R5", "late contender", code, 2);

        // R7: silent target
        launch(7, 4, 0, 0);
        finish_wait(code, ident);
        chk(code == 4, "R7", "selection timeout", code, 4);

        // R8: SEL with I/O while waiting
        launch(7, 4, 0, 3);
        finish_wait(code, ident);
        chk(code == 5, "R8", "reselection", code, 5);
        chk(!drv_atn && !drv_sel, "R8", "released", {drv_atn, drv_sel}, 0);

        // R9: target answers BSY but never REQ
        launch(1, 3, 2, 2);
        finish_wait(code, ident);
        chk(code == 6, "R9", "req timeout", code, 6);

        // R11: second start while busy is ignored
        launch(0, 7, 2, 1);
        repeat (40) @(negedge clk);
        iid = 3'd7; tid = 3'd3; lun = 3'd1; start = 1;
        @(negedge clk);
        start = 0;
        finish_wait(code, ident);
        chk(code == 1, "R11", "ignored restart code", code, 1);
        chk(ident == 8'h82, "R11", "ids kept", ident, 8'h82);

        // R3: bus never idle
        scen_bsy = 1;
        launch(4, 5, 0, 1);
        finish_wait(code, ident);
        scen_bsy = 0;
        chk(code == 3, "R3", "bus-free timeout", code, 3);

        repeat (5) @(negedge clk);
        summary();
    end
endmodule